// File: doc/BRIEF.md
# Additive-Pattern Memory Self-Test Engine

This block is a built-in self-test controller for a region of 32-bit words behind a simple synchronous memory port. A single start pulse runs three passes over the region in a fixed order. The first pass fills memory with an additive data sequence. The second pass reads each word back, checks it, and overwrites it with its bitwise complement. The third pass reads every word again and expects the complement. Each pass restarts the sequence from the same seed. After the first word, each value is the previous value plus a fixed step, modulo 2^32.

The engine has at most one memory access outstanding. After issuing a read, it waits a parameterised number of cycles for the data and only then compares it. The run stops at the first miscompare. At that point the engine latches the failing word address and a syndrome equal to the read data XOR the expected value. Independent of the result, the engine counts the clock cycles spent in each pass, so a run gives a pass/fail verdict and a per-pass timing profile. All status stays frozen from the end of a run until the next start pulse.

Top module: `memtest_engine`

## Requirements
- R1: Reset leaves busy, done, errFlag, failAddr, failSyndrome and all three cycle counters at zero. A start pulse sampled while idle or done clears all status. In the cycle after that pulse, busy is 1, done is 0 and all counters are 0.
- R2: The write pass stores seed + i*step (mod 2^32) at word address i for every i from 0 to WORDS-1, in ascending order at one word per cycle. The seed is 0x12ABCDEF and the step is 0x87654321.
- R3: The passes run strictly as write, then modify, then read. No read is issued before the write pass has finished. The pattern restarts from the seed at the first word of every pass.
- R4: In the modify pass, each word is read and compared with its pattern value exactly RD_LAT cycles after the read is issued. If it matches, the bitwise complement of the pattern is written back to the same address. After a clean run, every word holds the complement of its pattern and has been written exactly twice.
- R5: In the read pass, each word must equal the bitwise complement of its pattern value.
- R6: On the first miscompare, the engine sets errFlag and latches the word address and the syndrome (read data XOR expected value). It then stops with done high and issues no further accesses, so words after the failing one keep the content they had.
- R7: The cycle counters report the cycles spent in each pass. A clean run gives WORDS for the write pass, WORDS*(RD_LAT+2) for the modify pass and WORDS*(RD_LAT+1) for the read pass. A failing pass counts up to and including its comparing cycle, and later passes stay at 0.
- R8: Once done, done stays high and every status output holds its value until the next start pulse.
- R9: A read and a write are never issued in the same cycle, and every access addresses a word below WORDS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a run when sampled high while idle or done |
| memAddr | output | ADDR_W | Word address of the current access |
| memWdata | output | 32 | Write data |
| memWe | output | 1 | Write strobe |
| memRe | output | 1 | Read strobe |
| memRdata | input | 32 | Read data, valid RD_LAT cycles after the read strobe |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished, passed or failed |
| errFlag | output | 1 | The last run hit a miscompare |
| failAddr | output | ADDR_W | Word address of the first miscompare |
| failSyndrome | output | 32 | Read data XOR expected value at the first miscompare |
| cycWrite | output | CYC_W | Cycles spent in the write pass |
| cycModify | output | CYC_W | Cycles spent in the modify pass |
| cycRead | output | CYC_W | Cycles spent in the read pass |

## Verification
The bench uses a memory model that can corrupt a chosen write to a chosen address. This places miscompares at the first word and the last word, in either checking pass. A design that compares against the wrong cycle of the read pipeline, or forgets to reload the seed between passes, fails on a clean memory or reports the wrong syndrome. If the design keeps running after an error, the words after the failing one would show up complemented. If it writes back before comparing, the failing word would be complemented too. Exact per-pass cycle counts, including partial counts on failure, expose extra or missing wait states. A second start after a failure shows whether stale status survives.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

  localparam logic [31:0] PAT_SEED = 32'h12AB_CDEF;
  localparam logic [31:0] PAT_STEP = 32'h8765_4321;

  // which per-pass cycle counter advances this cycle
  typedef enum logic [1:0] {
    CNT_NONE = 2'd0,
    CNT_WR   = 2'd1,
    CNT_MOD  = 2'd2,
    CNT_RD   = 2'd3
  } cntSel_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic    clear;    // new run: wipe status, rewind pattern
    logic    rewind;   // next pass: address 0, pattern back to seed
    logic    advance;  // next word: address+1, pattern+step
    logic    capture;  // latch the failing address and syndrome
    logic    invData;  // use complement of pattern (write data / expected)
    cntSel_e cntSel;
  } dpCtrl_t;

endpackage

// File: rtl/memtest_dp.sv
module memtest_dp
  import memtest_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORDS  = 1024,
  parameter int CYC_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic              lastWord,
  output logic              mismatch,
  output logic              errFlag,
  output logic [ADDR_W-1:0] failAddr,
  output logic [31:0]       failSyndrome,
  output logic [CYC_W-1:0]  cycWrite,
  output logic [CYC_W-1:0]  cycModify,
  output logic [CYC_W-1:0]  cycRead
);

  localparam int NUM_PASSES = 3;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(WORDS - 1);

  logic [ADDR_W-1:0] addrQ;
  logic [31:0]       patQ;
  logic [31:0]       patSel;
  logic [31:0]       syndrome;
  logic [CYC_W-1:0]  cycCnt [NUM_PASSES];

  assign patSel   = ctl.invData ? ~patQ : patQ;
  assign syndrome = memRdata ^ patSel;
  assign mismatch = |syndrome;
  assign lastWord = (addrQ == LAST_ADDR);
  assign memAddr  = addrQ;
  assign memWdata = patSel;

  // address and pattern generator
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      patQ  <= PAT_SEED;
    end else if (ctl.clear || ctl.rewind) begin
      addrQ <= '0;
      patQ  <= PAT_SEED;
    end else if (ctl.advance) begin
      addrQ <= addrQ + ADDR_W'(1);
      patQ  <= patQ + PAT_STEP;
    end
  end

  // first-failure capture
  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) begin
      errFlag      <= 1'b0;
      failAddr     <= '0;
      failSyndrome <= '0;
    end else if (ctl.capture) begin
      errFlag      <= 1'b1;
      failAddr     <= addrQ;
      failSyndrome <= syndrome;
    end
  end

  // one cycle counter per pass
  for (genvar g = 0; g < NUM_PASSES; g++) begin : g_passCnt
    always_ff @(posedge clk) begin
      if (!rstN || ctl.clear) begin
        cycCnt[g] <= '0;
      end else if (2'(ctl.cntSel) == 2'(g + 1)) begin
        cycCnt[g] <= cycCnt[g] + CYC_W'(1);
      end
    end
  end

  assign cycWrite  = cycCnt[0];
  assign cycModify = cycCnt[1];
  assign cycRead   = cycCnt[2];

endmodule

// File: rtl/memtest_ctrl.sv
module memtest_ctrl
  import memtest_pkg::*;
#(
  parameter int RD_LAT = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    lastWord,
  input  logic    mismatch,
  output dpCtrl_t ctl,
  output logic    memWe,
  output logic    memRe,
  output logic    busy,
  output logic    done
);

  localparam int WAIT_W = $clog2(RD_LAT + 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(RD_LAT);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WRITE, ST_ISSUE, ST_WAIT, ST_FIX, ST_DONE
  } state_e;

  state_e            stateQ, stateD;
  logic              readPassQ, readPassD;
  logic [WAIT_W-1:0] waitQ, waitD;
  cntSel_e           checkCnt;

  assign checkCnt = readPassQ ? CNT_RD : CNT_MOD;

  always_comb begin
    stateD    = stateQ;
    readPassD = readPassQ;
    waitD     = waitQ;
    ctl       = '0;
    memWe     = 1'b0;
    memRe     = 1'b0;
    unique case (stateQ)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          ctl.clear = 1'b1;
          readPassD = 1'b0;
          stateD    = ST_WRITE;
        end
      end
      ST_WRITE: begin
        memWe      = 1'b1;
        ctl.cntSel = CNT_WR;
        if (lastWord) begin
          ctl.rewind = 1'b1;
          stateD     = ST_ISSUE;
        end else begin
          ctl.advance = 1'b1;
        end
      end
      ST_ISSUE: begin
        memRe      = 1'b1;
        ctl.cntSel = checkCnt;
        waitD      = WAIT_W'(1);
        stateD     = ST_WAIT;
      end
      ST_WAIT: begin
        ctl.cntSel  = checkCnt;
        ctl.invData = readPassQ;
        if (waitQ == WAIT_LAST) begin
          if (mismatch) begin
            ctl.capture = 1'b1;
            stateD      = ST_DONE;
          end else if (!readPassQ) begin
            stateD = ST_FIX;
          end else if (lastWord) begin
            stateD = ST_DONE;
          end else begin
            ctl.advance = 1'b1;
            stateD      = ST_ISSUE;
          end
        end else begin
          waitD = waitQ + WAIT_W'(1);
        end
      end
      ST_FIX: begin
        memWe       = 1'b1;
        ctl.invData = 1'b1;
        ctl.cntSel  = CNT_MOD;
        stateD      = ST_ISSUE;
        if (lastWord) begin
          ctl.rewind = 1'b1;
          readPassD  = 1'b1;
        end else begin
          ctl.advance = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      readPassQ <= 1'b0;
      waitQ     <= '0;
    end else begin
      stateQ    <= stateD;
      readPassQ <= readPassD;
      waitQ     <= waitD;
    end
  end

  assign busy = (stateQ != ST_IDLE) && (stateQ != ST_DONE);
  assign done = (stateQ == ST_DONE);

endmodule

// File: rtl/memtest_engine.sv
module memtest_engine
  import memtest_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORDS  = 1024,
  parameter int RD_LAT = 2,
  parameter int CYC_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic              memWe,
  output logic              memRe,
  input  logic [31:0]       memRdata,
  output logic              busy,
  output logic              done,
  output logic              errFlag,
  output logic [ADDR_W-1:0] failAddr,
  output logic [31:0]       failSyndrome,
  output logic [CYC_W-1:0]  cycWrite,
  output logic [CYC_W-1:0]  cycModify,
  output logic [CYC_W-1:0]  cycRead
);

  dpCtrl_t ctl;
  logic    lastWord;
  logic    mismatch;

  memtest_ctrl #(.RD_LAT(RD_LAT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .lastWord (lastWord),
    .mismatch (mismatch),
    .ctl      (ctl),
    .memWe    (memWe),
    .memRe    (memRe),
    .busy     (busy),
    .done     (done)
  );

  memtest_dp #(.ADDR_W(ADDR_W), .WORDS(WORDS), .CYC_W(CYC_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .memRdata     (memRdata),
    .memAddr      (memAddr),
    .memWdata     (memWdata),
    .lastWord     (lastWord),
    .mismatch     (mismatch),
    .errFlag      (errFlag),
    .failAddr     (failAddr),
    .failSyndrome (failSyndrome),
    .cycWrite     (cycWrite),
    .cycModify    (cycModify),
    .cycRead      (cycRead)
  );

endmodule

// File: rtl/memtest_chk.sv
module memtest_chk
  import memtest_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORDS  = 1024,
  parameter int CYC_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memWdata,
  input logic              memWe,
  input logic              memRe,
  input logic              busy,
  input logic              done,
  input logic              errFlag,
  input logic [ADDR_W-1:0] failAddr,
  input logic [31:0]       failSyndrome,
  input logic [CYC_W-1:0]  cycWrite,
  input logic [CYC_W-1:0]  cycModify,
  input logic [CYC_W-1:0]  cycRead
);

  p_busy_done_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  p_first_seed_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && cycModify == '0 && cycWrite == '0) |-> memWdata == PAT_SEED);

  p_step_add_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && cycModify == '0 && cycWrite != '0) |-> memWdata == $past(memWdata) + PAT_STEP);

  p_read_after_fill_r3: assert property (@(posedge clk) disable iff (!rstN)
    memRe |-> cycWrite == CYC_W'(WORDS));

  p_stop_on_error_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> (done && !memWe && !memRe));

  p_status_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(errFlag) && $stable(failAddr) &&
                          $stable(failSyndrome) && $stable(cycWrite) &&
                          $stable(cycModify) && $stable(cycRead)));

  p_one_access_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

  p_addr_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memWe || memRe) |-> memAddr < ADDR_W'(WORDS));

endmodule

bind memtest_engine memtest_chk #(.ADDR_W(ADDR_W), .WORDS(WORDS), .CYC_W(CYC_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .memAddr      (memAddr),
  .memWdata     (memWdata),
  .memWe        (memWe),
  .memRe        (memRe),
  .busy         (busy),
  .done         (done),
  .errFlag      (errFlag),
  .failAddr     (failAddr),
  .failSyndrome (failSyndrome),
  .cycWrite     (cycWrite),
  .cycModify    (cycModify),
  .cycRead      (cycRead)
);

// File: tb/memtest_engine_test.sv
module memtest_engine_test;

  localparam int ADDR_W = 5;
  localparam int WORDS  = 16;
  localparam int RD_LAT = 2;
  localparam int CYC_W  = 32;
  localparam logic [31:0] SEED = 32'h12AB_CDEF;
  localparam logic [31:0] STEP = 32'h8765_4321;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic [31:0]       memWdata;
  logic              memWe;
  logic              memRe;
  logic [31:0]       memRdata;
  logic              busy;
  logic              done;
  logic              errFlag;
  logic [ADDR_W-1:0] failAddr;
  logic [31:0]       failSyndrome;
  logic [CYC_W-1:0]  cycWrite;
  logic [CYC_W-1:0]  cycModify;
  logic [CYC_W-1:0]  cycRead;

  int vectors = 0;
  int miscompares = 0;

  // memory model with a one-shot write fault
  logic [31:0] mem   [WORDS];
  logic [31:0] snap  [WORDS];
  int          wrCnt [WORDS];
  logic [31:0] pipe  [RD_LAT];
  logic        snapTaken;
  logic        memClr = 1'b0;
  logic        faultEn = 1'b0;
  int          faultAddr = 0;
  int          faultWrite = 1;
  logic [31:0] faultMask = '0;

  always #2 clk = ~clk;

  memtest_engine #(.ADDR_W(ADDR_W), .WORDS(WORDS), .RD_LAT(RD_LAT), .CYC_W(CYC_W)) uut (
    .clk(clk), .rstN(rstN), .start(start),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRe(memRe),
    .memRdata(memRdata), .busy(busy), .done(done), .errFlag(errFlag),
    .failAddr(failAddr), .failSyndrome(failSyndrome),
    .cycWrite(cycWrite), .cycModify(cycModify), .cycRead(cycRead)
  );

  always @(posedge clk) begin
    if (memClr) begin
      for (int i = 0; i < WORDS; i++) begin
        mem[i]   <= 32'h0;
        wrCnt[i] <= 0;
      end
      snapTaken <= 1'b0;
    end else begin
      if (memWe) begin
        wrCnt[memAddr] <= wrCnt[memAddr] + 1;
        if (faultEn && int'(memAddr) == faultAddr && wrCnt[memAddr] == faultWrite - 1)
          mem[memAddr] <= memWdata ^ faultMask;
        else
          mem[memAddr] <= memWdata;
      end
      if (memRe && !snapTaken) begin
        snapTaken <= 1'b1;
        for (int i = 0; i < WORDS; i++) snap[i] <= mem[i];
      end
    end
    pipe[0] <= memRe ? mem[memAddr] : 32'hDEAD_BEEF;
    for (int i = 1; i < RD_LAT; i++) pipe[i] <= pipe[i-1];
  end

  assign memRdata = pipe[RD_LAT-1];

  function automatic logic [31:0] patOf(int idx);
    return SEED + STEP * 32'(idx);
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic prepMem(bit en, int addr, int nth, logic [31:0] mask);
    @(negedge clk);
    faultEn = en; faultAddr = addr; faultWrite = nth; faultMask = mask;
    memClr = 1'b1;
    @(negedge clk);
    memClr = 1'b0;
  endtask

  task automatic runTest();
    int guard = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R1: one cycle after the start edge everything is cleared
    check(busy == 1'b1 && done == 1'b0, "R1 busy after start", {busy, done}, 2'b10);
    check(errFlag == 1'b0 && cycWrite == 0 && cycModify == 0 && cycRead == 0,
          "R1 status cleared", {errFlag, cycWrite[15:0], cycModify[15:0]}, 0);
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(done, "R6 run finished", done, 1);
  endtask

  task automatic testReset();
    check(!busy && !done && !errFlag, "R1 reset flags", {busy, done, errFlag}, 0);
    check(failAddr == 0 && failSyndrome == 0, "R1 reset fail regs", failSyndrome, 0);
    check(cycWrite == 0 && cycModify == 0 && cycRead == 0, "R1 reset counters",
          cycWrite + cycModify + cycRead, 0);
  endtask

  task automatic testClean();
    bit okSnap = 1, okFinal = 1, okCnt = 1;
    prepMem(0, 0, 1, 0);
    runTest();
    check(errFlag == 0, "R5 clean run passes", errFlag, 0);
    for (int i = 0; i < WORDS; i++) begin
      if (snap[i] !== patOf(i)) okSnap = 0;
      if (mem[i] !== ~patOf(i)) okFinal = 0;
      if (wrCnt[i] != 2) okCnt = 0;
    end
    check(okSnap, "R2 write-pass image", snap[1], patOf(1));
    check(okFinal, "R3 R4 complement written with reseeded pattern", mem[WORDS-1], ~patOf(WORDS-1));
    check(okCnt, "R4 each word written twice", wrCnt[0], 2);
    check(cycWrite == WORDS, "R7 write cycles", cycWrite, WORDS);
    check(cycModify == WORDS * (RD_LAT + 2), "R7 modify cycles", cycModify, WORDS * (RD_LAT + 2));
    check(cycRead == WORDS * (RD_LAT + 1), "R7 read cycles", cycRead, WORDS * (RD_LAT + 1));
    repeat (20) @(negedge clk);
    check(done && !busy && errFlag == 0 && cycRead == WORDS * (RD_LAT + 1),
          "R8 status held", {done, busy, cycRead[15:0]}, {2'b10, 16'(WORDS * (RD_LAT + 1))});
  endtask

  task automatic testModifyFault(int addr, logic [31:0] mask);
    prepMem(1, addr, 1, mask);
    runTest();
    check(errFlag == 1, "R4 modify-pass miscompare flagged", errFlag, 1);
    check(failAddr == addr, "R6 fail address", failAddr, addr);
    check(failSyndrome == mask, "R6 syndrome", failSyndrome, mask);
    check(cycModify == addr * (RD_LAT + 2) + RD_LAT + 1, "R7 partial modify cycles",
          cycModify, addr * (RD_LAT + 2) + RD_LAT + 1);
    check(cycRead == 0, "R7 read pass not entered", cycRead, 0);
    check(mem[addr] == (patOf(addr) ^ mask), "R6 failing word not written back",
          mem[addr], patOf(addr) ^ mask);
    if (addr + 1 < WORDS)
      check(mem[addr+1] == patOf(addr+1), "R6 stop after first error", mem[addr+1], patOf(addr+1));
    if (addr > 0)
      check(mem[addr-1] == ~patOf(addr-1), "R4 earlier word complemented", mem[addr-1], ~patOf(addr-1));
    repeat (10) @(negedge clk);
    check(failAddr == addr && errFlag, "R8 fail status held", failAddr, addr);
  endtask

  task automatic testReadFault(int addr, logic [31:0] mask);
    prepMem(1, addr, 2, mask);
    runTest();
    check(errFlag == 1, "R5 read-pass miscompare flagged", errFlag, 1);
    check(failAddr == addr, "R5 fail address", failAddr, addr);
    check(failSyndrome == mask, "R5 syndrome", failSyndrome, mask);
    check(cycModify == WORDS * (RD_LAT + 2), "R7 full modify cycles", cycModify, WORDS * (RD_LAT + 2));
    check(cycRead == addr * (RD_LAT + 1) + RD_LAT + 1, "R7 partial read cycles",
          cycRead, addr * (RD_LAT + 1) + RD_LAT + 1);
  endtask

  initial begin
    #(4 * 150000);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testClean();
    testModifyFault(5, 32'h0001_0080);
    testModifyFault(0, 32'hFFFF_0000);
    testModifyFault(WORDS - 1, 32'h0000_0001);
    testReadFault(WORDS - 1, 32'h8000_0001);
    testReadFault(3, 32'h00F0_0F00);
    testClean();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule